// File: doc/BRIEF.md
# Counting Semaphore with Ordered Wait Queue

This block arbitrates a pool of identical resource units among a fixed set of requesting agents. It holds an integer count, bounded by a configured maximum and loaded with a configured start value. Each agent has a wait strobe, a post strobe and a grant output. A wait takes a unit at once when one is available. When none is available, the agent's index goes into a first-in first-out queue. A post returns a unit, or hands it straight to the oldest queued agent.

All strobes of one clock cycle are folded into a single update. Posts are handled first, then waits, each group in ascending agent index. If the start value is zero, one agent's post must come before another agent's wait can complete, so the block can also enforce ordering between agents. Invalid waits set a sticky error flag and change nothing else.

Top module: `cnt_sema`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `count_o` with `INIT_CNT`, empties the queue (`q_level_o` = 0), clears `err_o` and drives every `grant` bit to 0.
- R2: A wait from agent i while the count is above zero lowers the count by one. Bit i of `grant` is 1 in the cycle after the strobe.
- R3: A wait while the count is zero puts the agent's index at the tail of the queue. `q_level_o` rises by one and no grant is given.
- R4: A post while the queue is empty raises the count by one if it is below `MAX_CNT`. At `MAX_CNT` the count stays where it is.
- R5: A post while the queue is non-empty removes the head entry and grants that agent. The count is left unchanged and `q_level_o` drops by one.
- R6: Queued agents are released strictly in the order in which they were queued.
- R7: When posts and waits arrive in the same cycle, all posts are applied first and the waits then see the resulting count and queue.
- R8: Several waits in one cycle are served or queued in ascending agent index (agent 0 first).
- R9: A wait from an agent that is already queued, or a wait that arrives while `q_level_o` = `QDEPTH`, sets `err_o` and leaves count and queue unchanged. Once set, `err_o` stays set until reset.
- R10: Each grant is a single-cycle pulse and needs a new strobe to recur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wait_req | input | N_AGENTS | Per-agent wait strobe |
| post_req | input | N_AGENTS | Per-agent post strobe |
| grant | output | N_AGENTS | Per-agent one-cycle grant pulse |
| count_o | output | $clog2(MAX_CNT+1) | Current unit count |
| q_level_o | output | $clog2(QDEPTH+1) | Number of queued agents |
| err_o | output | 1 | Sticky misuse flag |

## Verification
The hardest state to reach from the ports is a full queue that then receives a same-cycle mix of posts and waits. In that case a post may release an agent that is also waiting again in the same cycle, and the ordering rules decide whether the agent is served, queued again or flagged. The stimulus gets there in two steps. A lone post followed by four simultaneous waits fills the queue. A long pseudo-random sweep then applies every mix of strobes, with periodic resets, against an arithmetic model of count, queue and error flag.

// File: rtl/sema_pkg.sv
package sema_pkg;
   // width of an index able to name n distinct items (at least one bit)
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width of a value able to hold 0..n
   function automatic int unsigned val_w(input int unsigned n);
      return (n > 0) ? $clog2(n + 1) : 1;
   endfunction
endpackage

// File: rtl/sema_update.sv
module sema_update #(
   parameter int unsigned N    = 4,
   parameter int unsigned QD   = 3,
   parameter int unsigned MAXC = 3,
   parameter int unsigned IDW  = 2,
   parameter int unsigned CW   = 2,
   parameter int unsigned LW   = 2
) (
   input  logic [CW-1:0]           cnt_q,
   input  logic [QD-1:0][IDW-1:0]  q_q,
   input  logic [LW-1:0]           lvl_q,
   input  logic [N-1:0]            inq_q,
   input  logic                    err_q,
   input  logic [N-1:0]            wait_req,
   input  logic [N-1:0]            post_req,
   output logic [CW-1:0]           cnt_d,
   output logic [QD-1:0][IDW-1:0]  q_d,
   output logic [LW-1:0]           lvl_d,
   output logic [N-1:0]            inq_d,
   output logic                    err_d,
   output logic [N-1:0]            grant_d
);
   localparam logic [CW-1:0] MAXV = CW'(MAXC);
   localparam logic [LW-1:0] FULL = LW'(QD);

   always_comb begin
      cnt_d   = cnt_q;
      q_d     = q_q;
      lvl_d   = lvl_q;
      inq_d   = inq_q;
      err_d   = err_q;
      grant_d = '0;
      // returns first, lowest agent index first
      for (int i = 0; i < N; i++) begin
         if (post_req[i]) begin
            if (lvl_d != '0) begin
               grant_d[q_d[0]] = 1'b1;
               inq_d[q_d[0]]   = 1'b0;
               for (int j = 0; j < QD - 1; j++) q_d[j] = q_d[j+1];
               q_d[QD-1] = '0;
               lvl_d     = lvl_d - 1'b1;
            end else if (cnt_d < MAXV) begin
               cnt_d = cnt_d + 1'b1;
            end
         end
      end
      // then acquisitions, lowest agent index first
      for (int i = 0; i < N; i++) begin
         if (wait_req[i]) begin
            if (inq_d[i] || (lvl_d == FULL)) begin
               err_d = 1'b1;
            end else if (cnt_d != '0) begin
               cnt_d      = cnt_d - 1'b1;
               grant_d[i] = 1'b1;
            end else begin
               for (int j = 0; j < QD; j++)
                  if (LW'(j) == lvl_d) q_d[j] = IDW'(i);
               lvl_d    = lvl_d + 1'b1;
               inq_d[i] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sema_regs.sv
module sema_regs #(
   parameter int unsigned N    = 4,
   parameter int unsigned QD   = 3,
   parameter int unsigned INIT = 0,
   parameter int unsigned IDW  = 2,
   parameter int unsigned CW   = 2,
   parameter int unsigned LW   = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [CW-1:0]           cnt_d,
   input  logic [QD-1:0][IDW-1:0]  q_d,
   input  logic [LW-1:0]           lvl_d,
   input  logic [N-1:0]            inq_d,
   input  logic                    err_d,
   input  logic [N-1:0]            grant_d,
   output logic [CW-1:0]           cnt_q,
   output logic [QD-1:0][IDW-1:0]  q_q,
   output logic [LW-1:0]           lvl_q,
   output logic [N-1:0]            inq_q,
   output logic                    err_q,
   output logic [N-1:0]            grant_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= CW'(INIT);
         lvl_q   <= '0;
         inq_q   <= '0;
         err_q   <= 1'b0;
         grant_q <= '0;
      end else begin
         cnt_q   <= cnt_d;
         lvl_q   <= lvl_d;
         inq_q   <= inq_d;
         err_q   <= err_d;
         grant_q <= grant_d;
      end
   end

   // queue slots: contents are don't-care beyond the level, so no reset
   for (genvar s = 0; s < QD; s++) begin : g_slot
      always_ff @(posedge clk) q_q[s] <= q_d[s];
   end
endmodule

// File: rtl/cnt_sema.sv
module cnt_sema #(
   parameter int unsigned N_AGENTS = 4,
   parameter int unsigned QDEPTH   = 3,
   parameter int unsigned MAX_CNT  = 3,
   parameter int unsigned INIT_CNT = 0,
   localparam int unsigned IDW     = sema_pkg::idx_w(N_AGENTS),
   localparam int unsigned CNT_W   = sema_pkg::val_w(MAX_CNT),
   localparam int unsigned LVL_W   = sema_pkg::val_w(QDEPTH)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_AGENTS-1:0] wait_req,
   input  logic [N_AGENTS-1:0] post_req,
   output logic [N_AGENTS-1:0] grant,
   output logic [CNT_W-1:0]    count_o,
   output logic [LVL_W-1:0]    q_level_o,
   output logic                err_o
);
   if (N_AGENTS < 1)        begin : g_bad_n    $error("N_AGENTS must be at least 1"); end
   if (QDEPTH < 1)          begin : g_bad_q    $error("QDEPTH must be at least 1"); end
   if (QDEPTH > N_AGENTS)   begin : g_bad_qn   $error("QDEPTH above N_AGENTS is unreachable"); end
   if (MAX_CNT < 1)         begin : g_bad_max  $error("MAX_CNT must be at least 1"); end
   if (INIT_CNT > MAX_CNT)  begin : g_bad_init $error("INIT_CNT exceeds MAX_CNT"); end

   logic [CNT_W-1:0]           cnt_q, cnt_d;
   logic [QDEPTH-1:0][IDW-1:0] q_q, q_d;
   logic [LVL_W-1:0]           lvl_q, lvl_d;
   logic [N_AGENTS-1:0]        inq_q, inq_d, grant_d, grant_q;
   logic                       err_q, err_d;

   sema_update #(
      .N(N_AGENTS), .QD(QDEPTH), .MAXC(MAX_CNT),
      .IDW(IDW), .CW(CNT_W), .LW(LVL_W)
   ) u_upd (
      .cnt_q(cnt_q), .q_q(q_q), .lvl_q(lvl_q), .inq_q(inq_q), .err_q(err_q),
      .wait_req(wait_req), .post_req(post_req),
      .cnt_d(cnt_d), .q_d(q_d), .lvl_d(lvl_d), .inq_d(inq_d), .err_d(err_d),
      .grant_d(grant_d)
   );

   sema_regs #(
      .N(N_AGENTS), .QD(QDEPTH), .INIT(INIT_CNT),
      .IDW(IDW), .CW(CNT_W), .LW(LVL_W)
   ) u_regs (
      .clk(clk), .rst(rst),
      .cnt_d(cnt_d), .q_d(q_d), .lvl_d(lvl_d), .inq_d(inq_d), .err_d(err_d),
      .grant_d(grant_d),
      .cnt_q(cnt_q), .q_q(q_q), .lvl_q(lvl_q), .inq_q(inq_q), .err_q(err_q),
      .grant_q(grant_q)
   );

   assign grant     = grant_q;
   assign count_o   = cnt_q;
   assign q_level_o = lvl_q;
   assign err_o     = err_q;
endmodule

// File: rtl/sema_chk.sv
module sema_chk #(
   parameter int unsigned N_AGENTS = 4,
   parameter int unsigned QDEPTH   = 3,
   parameter int unsigned MAX_CNT  = 3,
   parameter int unsigned CNT_W    = 2,
   parameter int unsigned LVL_W    = 2
) (
   input logic                clk,
   input logic                rst,
   input logic [N_AGENTS-1:0] wait_req,
   input logic [N_AGENTS-1:0] post_req,
   input logic [N_AGENTS-1:0] grant,
   input logic [CNT_W-1:0]    count_o,
   input logic [LVL_W-1:0]    q_level_o,
   input logic                err_o
);
   // R4: the count never passes its ceiling
   p_count_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
      count_o <= CNT_W'(MAX_CNT));

   // R9: occupancy never passes the queue depth
   p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
      q_level_o <= LVL_W'(QDEPTH));

   // R3: agents only queue while no unit is free
   p_queue_implies_empty_r3: assert property (@(posedge clk) disable iff (rst)
      (q_level_o != '0) |-> (count_o == '0));

   // R9: the error flag is sticky
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o);

   // R10: a grant follows a wait from that agent or some post
   for (genvar a = 0; a < N_AGENTS; a++) begin : g_ag
      p_grant_cause_r10: assert property (@(posedge clk) disable iff (rst)
         $rose(grant[a]) |-> ($past(wait_req[a]) || ($past(post_req) != '0)));
   end

   // R2: with nothing queued and no strobes, count stays put
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
      (wait_req == '0 && post_req == '0) |=> $stable(count_o));
endmodule

bind cnt_sema sema_chk #(
   .N_AGENTS(N_AGENTS), .QDEPTH(QDEPTH), .MAX_CNT(MAX_CNT),
   .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst(rst), .wait_req(wait_req), .post_req(post_req),
   .grant(grant), .count_o(count_o), .q_level_o(q_level_o), .err_o(err_o)
);

// File: tb/cnt_sema_tb.sv
`timescale 1ns/1ps
module cnt_sema_tb;
   localparam int N = 4, QD = 3, MAXC = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] wait_req = '0, post_req = '0;
   logic [3:0] grant;
   logic [1:0] count_o, q_level_o;
   logic       err_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   int mcnt, mlvl;
   int mq [QD];
   bit minq [N];
   bit merr;
   logic [3:0] mg;

   cnt_sema #(.N_AGENTS(N), .QDEPTH(QD), .MAX_CNT(MAXC), .INIT_CNT(0)) u_dut (
      .clk(clk), .rst(rst), .wait_req(wait_req), .post_req(post_req),
      .grant(grant), .count_o(count_o), .q_level_o(q_level_o), .err_o(err_o)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got grant/cnt/lvl/err=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      mcnt = 0; mlvl = 0; merr = 0; mg = '0;
      for (int i = 0; i < N; i++) minq[i] = 0;
      for (int j = 0; j < QD; j++) mq[j] = 0;
   endtask

   task automatic model_step(input logic [3:0] w, input logic [3:0] p);
      mg = '0;
      for (int i = 0; i < N; i++) if (p[i]) begin
         if (mlvl > 0) begin
            mg[mq[0]] = 1'b1; minq[mq[0]] = 0;
            for (int j = 0; j < QD - 1; j++) mq[j] = mq[j+1];
            mlvl--;
         end else if (mcnt < MAXC) mcnt++;
      end
      for (int i = 0; i < N; i++) if (w[i]) begin
         if (minq[i] || mlvl == QD) merr = 1;
         else if (mcnt > 0) begin mcnt--; mg[i] = 1'b1; end
         else begin mq[mlvl] = i; mlvl++; minq[i] = 1; end
      end
   endtask

   function automatic logic [8:0] observed();
      return {grant, count_o, q_level_o, err_o};
   endfunction

   function automatic logic [8:0] expected();
      return {mg, 2'(mcnt), 2'(mlvl), merr};
   endfunction

   task automatic step(input string tag, input logic [3:0] w, input logic [3:0] p);
      @(negedge clk);
      wait_req = w; post_req = p;
      @(posedge clk); #1;
      model_step(w, p);
      check(tag, observed(), expected());
      @(negedge clk);
      wait_req = '0; post_req = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wait_req = '0; post_req = '0;
      @(posedge clk); @(posedge clk); #1;
      model_reset();
      check("R1 reset", observed(), 9'b0000_00_00_0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      model_reset();
      do_reset();

      // R4 saturation at MAX_CNT
      for (int k = 0; k < 5; k++) step("R4 post saturate", 4'b0000, 4'b0001);
      check("R4 ceiling value", {5'b0, count_o, 2'b00}, {5'b0, 2'd3, 2'b00});
      // R2 immediate grant, R10 pulse ends
      step("R2 wait takes unit", 4'b0010, 4'b0000);
      check("R2 grant agent1", {5'b0, grant}, 9'b0_0000_0010);
      step("R10 grant drops", 4'b0000, 4'b0000);
      check("R10 single pulse", {5'b0, grant}, 9'd0);

      // R3/R5/R6 FIFO wake order from zero count
      do_reset();
      step("R3 queue a2", 4'b0100, 4'b0000);
      step("R3 queue a0", 4'b0001, 4'b0000);
      step("R3 queue a3", 4'b1000, 4'b0000);
      check("R3 level three", {7'b0, q_level_o}, 9'd3);
      step("R5 wake head", 4'b0000, 4'b0010);
      check("R6 first out a2", {5'b0, grant}, 9'b0_0000_0100);
      step("R6 wake next", 4'b0000, 4'b0010);
      check("R6 second out a0", {5'b0, grant}, 9'b0_0000_0001);
      step("R6 wake last", 4'b0000, 4'b0010);
      check("R6 third out a3", {5'b0, grant}, 9'b0_0000_1000);
      check("R5 count unchanged", {7'b0, count_o}, 9'd0);

      // R7 post then wait in one cycle
      step("R7 post+wait", 4'b0010, 4'b0001);
      check("R7 served in same cycle", {5'b0, grant}, 9'b0_0000_0010);

      // R8 simultaneous waits: a0 served, a1..a3 queued in order
      step("R8 one unit", 4'b0000, 4'b0100);
      step("R8 all wait", 4'b1111, 4'b0000);
      check("R8 lowest index served", {5'b0, grant}, 9'b0_0000_0001);
      // R9 full queue
      step("R9 wait when full", 4'b0001, 4'b0000);
      check("R9 err set", {8'b0, err_o}, 9'd1);
      step("R9 err sticky", 4'b0000, 4'b0000);
      step("R8 wake order a1", 4'b0000, 4'b0001);
      check("R8 a1 released first", {5'b0, grant}, 9'b0_0000_0010);

      // R9 duplicate wait
      do_reset();
      step("R9 first wait", 4'b0010, 4'b0000);
      step("R9 duplicate wait", 4'b0010, 4'b0000);
      check("R9 level kept", {7'b0, q_level_o}, 9'd1);

      // R7 release and re-wait of the same agent in one cycle
      step("R7 pop and rewait", 4'b0010, 4'b0001);

      // sweep over strobe mixes with periodic reset
      lfsr = 16'hACE1;
      for (int c = 0; c < 4000; c++) begin
         if (c % 97 == 0) do_reset();
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step("R6 R7 R8 sweep", lfsr[3:0] & lfsr[11:8], lfsr[7:4] & lfsr[15:12]);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule